// File: doc/BRIEF.md
# CAN Transmit Queue Controller

This block holds one queue of outgoing CAN frames for a frame engine. Software adds frames through a push port. The block keeps a message count, an empty flag, a full flag and a sticky overflow flag. It presents the oldest stored frame to an external transmit scheduler. A 3-bit depth code sets the capacity of the queue, an enable bit switches the queue on, and a mode bit chooses whether every completed frame raises the transmit interrupt flag. Software clears that flag with a write strobe.

The queue can be chosen for transmission only at a selection point. One selection point is any cycle in which the bus is idle. The other is the cycle of the CRC-delimiter strobe of the frame now on the bus. When the scheduler grants a request, the queue is committed to that frame. The frame then ends with exactly one of three strobes: success, error or arbitration loss. Only success removes the frame. Clearing the enable bit during a commitment does not abort the frame. Once the queue is uncommitted, a cleared enable bit flushes it.

Top module: `can_txq_ctrl`

## Requirements
- R1: `txq_req` is 1 only when `cfg_en` is 1, `cfg_depth` is not 3'b000 and `msg_count` is at least 1.
- R2: The capacity follows the depth code: 3'b000 gives 0, 3'b001 gives 4, 3'b010 gives 8, and 3'b011 or above gives 16. `full` is 1 exactly when `msg_count` is at least the capacity.
- R3: A push while `full` is 1 leaves `msg_count` unchanged and sets `overflow`, which then stays 1 until reset.
- R4: While the queue is not committed and is eligible, `txq_req` is 1 in any cycle in which `bus_idle` is 1 or `crc_delim` is 1. In all other cycles it is 0.
- R5: A `sched_grant` in a cycle with `txq_req` at 1 commits the queue. While committed, `txq_req` is 0 and `head_frame` does not change.
- R6: `tx_done` while committed lowers `msg_count` by one and moves `head_frame` to the next frame in push order. `tx_done` while not committed is ignored. A push and a completion in the same cycle leave the count unchanged.
- R7: With `cfg_irq_each` at 1, each successful transmission sets `tx_irq`. With `cfg_irq_each` at 0, `tx_irq` is not set. `irq_clr` clears `tx_irq`, but a completion in the same cycle wins.
- R8: `empty` is 1 exactly when `msg_count` is 0, including after the last frame completes.
- R9: Clearing `cfg_en` while committed does not abort the frame. The count is kept until `tx_done`, `tx_error` or `tx_arb_lost` arrives.
- R10: `tx_error` or `tx_arb_lost` while committed leaves `msg_count` and `head_frame` unchanged. The queue may request again at the next selection point.
- R11: `cfg_en` at 0 while not committed empties the queue on the next edge. Pushes while `cfg_en` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Queue enable |
| cfg_depth | input | 3 | Capacity code |
| cfg_irq_each | input | 1 | Raise interrupt on every completed frame |
| push_valid | input | 1 | Software push strobe |
| push_frame | input | FRAME_W | Frame to enqueue |
| irq_clr | input | 1 | Software clear of tx_irq |
| bus_idle | input | 1 | Bus idle level |
| crc_delim | input | 1 | CRC-delimiter strobe of the current frame |
| sched_grant | input | 1 | Scheduler picks this queue |
| tx_done | input | 1 | Frame sent successfully |
| tx_error | input | 1 | Frame ended by error |
| tx_arb_lost | input | 1 | Frame lost arbitration |
| txq_req | output | 1 | Queue offers its head frame |
| head_frame | output | FRAME_W | Oldest stored frame |
| msg_count | output | CNT_W | Stored message count |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count has reached capacity |
| tx_irq | output | 1 | Transmit interrupt flag |
| overflow | output | 1 | Sticky push-while-full flag |

## Verification
The assertions check the following on every cycle:
- requests appear only inside a selection window, only from a non-empty enabled queue;
- a commitment survives until one of the three end strobes;
- counts step correctly on completion and stay put on a rejected push or a failed attempt;
- the interrupt and overflow flags follow their events.

Only the bench scenarios can show the rest:
- frames leave in push order;
- each depth code gives its own capacity, including the clamp above code 3'b011;
- a disabled queue flushes only after the committed frame ends;
- a completion beats a simultaneous interrupt clear.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;

  // Capacity selected by the 3-bit depth code, clamped to the storage size.
  function automatic int unsigned depth_cap(input logic [2:0] code,
                                            input int unsigned max_depth);
    int unsigned c;
    case (code)
      3'd0:    c = 0;
      3'd1:    c = 4;
      3'd2:    c = 8;
      default: c = 16;
    endcase
    if (c > max_depth) c = max_depth;
    return c;
  endfunction

  // Next count value given the three count events.
  function automatic int unsigned count_next(input int unsigned cur,
                                             input logic inc,
                                             input logic dec,
                                             input logic clr);
    if (clr) return 0;
    return cur + int'(inc) - int'(dec);
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int FRAME_W = 32,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               rd_adv,
  input  logic               clr,
  output logic [FRAME_W-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FRAME_W-1:0] mem [DEPTH];
  logic [PW-1:0]      wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en)  wr_ptr <= ptr_inc(wr_ptr);
      if (rd_adv) rd_ptr <= ptr_inc(rd_ptr);
    end
  end

  assign head = mem[rd_ptr];

  // R6: the read pointer moves only on a completed frame or a flush
  p_rd_moves_on_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_adv && !clr |=> $stable(rd_ptr));
endmodule

// File: rtl/txq_count.sv
module txq_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  import can_txq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= CNT_W'(count_next(int'(count), inc, dec, clr));
  end

  // R6: one completion without a push lowers the count by exactly one
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !inc && !clr |=> count == $past(count) - 1'b1);
  // R6: push and completion together leave the count unchanged
  p_count_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec && inc && !clr |=> $stable(count));
endmodule

// File: rtl/txq_sched_if.sv
module txq_sched_if (
  input  logic clk,
  input  logic rst_n,
  input  logic eligible,
  input  logic bus_idle,
  input  logic crc_delim,
  input  logic grant,
  input  logic done,
  input  logic err,
  input  logic arb_lost,
  output logic req,
  output logic committed,
  output logic commit_evt,
  output logic pop_evt,
  output logic release_evt
);
  logic window;

  assign window      = bus_idle || crc_delim;
  assign req         = eligible && !committed && window;
  assign commit_evt  = req && grant;
  assign pop_evt     = committed && done;
  assign release_evt = committed && !done && (err || arb_lost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       committed <= 1'b0;
    else if (commit_evt)              committed <= 1'b1;
    else if (pop_evt || release_evt)  committed <= 1'b0;
  end

  // R4: a request only appears at a selection point
  p_req_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> bus_idle || crc_delim);
  // R9: a commitment is held until one of the end strobes arrives
  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    committed && !done && !err && !arb_lost |=> committed);
  // R5: a granted request moves the queue into the committed state
  p_grant_commits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> committed && !req);
endmodule

// File: rtl/can_txq_ctrl.sv
module can_txq_ctrl #(
  parameter int FRAME_W   = 32,
  parameter int MAX_DEPTH = 16,
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [2:0]         cfg_depth,
  input  logic               cfg_irq_each,
  input  logic               push_valid,
  input  logic [FRAME_W-1:0] push_frame,
  input  logic               irq_clr,
  input  logic               bus_idle,
  input  logic               crc_delim,
  input  logic               sched_grant,
  input  logic               tx_done,
  input  logic               tx_error,
  input  logic               tx_arb_lost,
  output logic               txq_req,
  output logic [FRAME_W-1:0] head_frame,
  output logic [CNT_W-1:0]   msg_count,
  output logic               empty,
  output logic               full,
  output logic               tx_irq,
  output logic               overflow
);
  import can_txq_pkg::*;

  logic [CNT_W-1:0] cap;
  logic eligible, committed, commit_evt, pop_evt, release_evt;
  logic push_acc, push_rej, flush_evt;

  assign cap       = CNT_W'(depth_cap(cfg_depth, MAX_DEPTH));
  assign empty     = (msg_count == '0);
  assign full      = (msg_count >= cap);
  assign eligible  = cfg_en && (cfg_depth != 3'd0) && !empty;
  assign flush_evt = !cfg_en && !committed;
  assign push_acc  = push_valid && cfg_en && !full;
  assign push_rej  = push_valid && cfg_en && full;

  txq_sched_if u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .eligible   (eligible),
    .bus_idle   (bus_idle),
    .crc_delim  (crc_delim),
    .grant      (sched_grant),
    .done       (tx_done),
    .err        (tx_error),
    .arb_lost   (tx_arb_lost),
    .req        (txq_req),
    .committed  (committed),
    .commit_evt (commit_evt),
    .pop_evt    (pop_evt),
    .release_evt(release_evt)
  );

  txq_count #(.CNT_W(CNT_W)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (push_acc),
    .dec  (pop_evt),
    .clr  (flush_evt),
    .count(msg_count)
  );

  txq_store #(.FRAME_W(FRAME_W), .DEPTH(MAX_DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (push_acc),
    .wr_data(push_frame),
    .rd_adv (pop_evt),
    .clr    (flush_evt),
    .head   (head_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (pop_evt && cfg_irq_each) tx_irq <= 1'b1;
      else if (irq_clr)            tx_irq <= 1'b0;
      if (push_rej)                overflow <= 1'b1;
    end
  end

  // R1: only a non-empty enabled queue requests
  p_req_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    txq_req |-> cfg_en && msg_count != '0);
  // R3: a push at capacity does not change the count
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_rej && !pop_evt |=> $stable(msg_count));
  // R3: overflow is sticky
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7: per-message mode raises the interrupt on every completion
  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt && cfg_irq_each |=> tx_irq);
  // R10: a failed attempt keeps the stored frames
  p_fail_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt && !push_acc |=> $stable(msg_count));
  // R11: a flush leaves the queue empty
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> empty);
endmodule

// File: tb/tb_can_txq_ctrl.sv
module tb_can_txq_ctrl;
  localparam int FW = 32;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_irq_each = 1'b0;
  logic [2:0] cfg_depth = 3'd1;
  logic push_valid = 1'b0, irq_clr = 1'b0, bus_idle = 1'b0, crc_delim = 1'b0;
  logic sched_grant = 1'b0, tx_done = 1'b0, tx_error = 1'b0, tx_arb_lost = 1'b0;
  logic [FW-1:0] push_frame = '0;
  logic txq_req, empty, full, tx_irq, overflow;
  logic [FW-1:0] head_frame;
  logic [CW-1:0] msg_count;

  int n_chk = 0, n_bad = 0, nid = 0;
  logic [FW-1:0] first_id;

  always #2 clk = ~clk;

  can_txq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_depth(cfg_depth),
    .cfg_irq_each(cfg_irq_each), .push_valid(push_valid), .push_frame(push_frame),
    .irq_clr(irq_clr), .bus_idle(bus_idle), .crc_delim(crc_delim),
    .sched_grant(sched_grant), .tx_done(tx_done), .tx_error(tx_error),
    .tx_arb_lost(tx_arb_lost), .txq_req(txq_req), .head_frame(head_frame),
    .msg_count(msg_count), .empty(empty), .full(full), .tx_irq(tx_irq),
    .overflow(overflow)
  );

  // Vector fields: [10] push [9] bus_idle [8] grant [7] done [6] error
  //                [5] expected request [4:0] expected count after the edge
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    11'b1_0_0_0_0_0_00001,
    11'b1_0_0_0_0_0_00010,
    11'b0_1_0_0_0_1_00010,
    11'b0_1_1_0_0_1_00010,
    11'b0_1_0_0_0_0_00010,
    11'b0_0_0_1_0_0_00001,
    11'b0_1_1_0_0_1_00001,
    11'b0_0_0_0_1_0_00001,
    11'b0_1_1_0_0_1_00001,
    11'b1_0_0_1_0_0_00001,
    11'b1_0_0_0_0_0_00010,
    11'b1_0_0_0_0_0_00011,
    11'b1_0_0_0_0_0_00100,
    11'b0_0_0_1_0_0_00100
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [FW-1:0] frame_of(input int id);
    return 32'hC0DE_0000 | FW'(id);
  endfunction

  task automatic push_one();
    nid++;
    push_frame = frame_of(nid);
    push_valid = 1'b1;
    tick();
    push_valid = 1'b0;
  endtask

  task automatic commit();
    bus_idle = 1'b1; sched_grant = 1'b1;
    tick();
    bus_idle = 1'b0; sched_grant = 1'b0;
  endtask

  task automatic finish_tx();
    tx_done = 1'b1;
    tick();
    tx_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R8, R1, R7, R3)
    check("R8 empty at reset", 32'(empty), 1);
    check("R6 count at reset", 32'(msg_count), 0);
    check("R1 req at reset", 32'(txq_req), 0);
    check("R7 irq at reset", 32'(tx_irq), 0);
    check("R3 overflow at reset", 32'(overflow), 0);
    rst_n = 1'b1;
    cfg_en = 1'b1;
    tick();

    // Table walk: capacity 4, per-message interrupt off
    for (int i = 0; i < NV; i++) begin
      push_valid  = VEC[i][10];
      if (VEC[i][10]) begin nid++; push_frame = frame_of(nid); end
      bus_idle    = VEC[i][9];
      sched_grant = VEC[i][8];
      tx_done     = VEC[i][7];
      tx_error    = VEC[i][6];
      #1;
      check("R4 request in window", 32'(txq_req), 32'(VEC[i][5]));
      tick();
      check("R6 count after vector", 32'(msg_count), 32'(VEC[i][4:0]));
      push_valid = 1'b0; bus_idle = 1'b0; sched_grant = 1'b0;
      tx_done = 1'b0; tx_error = 1'b0;
    end
    check("R7 no irq when mode off", 32'(tx_irq), 0);
    check("R2 full at 4", 32'(full), 1);

    // R3 overflow
    push_one();
    check("R3 count held when full", 32'(msg_count), 4);
    check("R3 overflow set", 32'(overflow), 1);

    // R11 flush and ignored pushes
    cfg_en = 1'b0;
    tick();
    check("R11 flushed count", 32'(msg_count), 0);
    check("R8 empty after flush", 32'(empty), 1);
    push_one();
    check("R11 push ignored when disabled", 32'(msg_count), 0);

    // R2 capacities
    cfg_en = 1'b1; cfg_depth = 3'd2;
    repeat (7) push_one();
    check("R2 not full at 7 of 8", 32'(full), 0);
    push_one();
    check("R2 full at 8", 32'(full), 1);
    cfg_depth = 3'd5;
    #1;
    check("R2 clamp code not full at 8", 32'(full), 0);
    repeat (8) push_one();
    check("R2 count at clamp", 32'(msg_count), 16);
    check("R2 full at 16", 32'(full), 1);

    // R1 depth code zero blocks request
    cfg_depth = 3'd0; bus_idle = 1'b1;
    #1;
    check("R1 no request at code 0", 32'(txq_req), 0);
    check("R2 code 0 full", 32'(full), 1);
    bus_idle = 1'b0; cfg_depth = 3'd1; cfg_en = 1'b0;
    tick();
    cfg_en = 1'b1;

    // R6 push order, R5 head held while committed
    push_one(); first_id = frame_of(nid);
    push_one(); push_one();
    check("R6 head is oldest", head_frame, first_id);
    commit();
    check("R5 head held while committed", head_frame, first_id);
    check("R5 no request while committed", 32'(txq_req), 0);
    finish_tx();
    check("R6 head advanced", head_frame, first_id + 1);
    check("R6 count after done", 32'(msg_count), 2);

    // R10 arbitration loss
    commit();
    tx_arb_lost = 1'b1; tick(); tx_arb_lost = 1'b0;
    check("R10 count kept", 32'(msg_count), 2);
    check("R10 head kept", head_frame, first_id + 1);
    crc_delim = 1'b1;
    #1;
    check("R4 request at CRC delimiter", 32'(txq_req), 1);
    sched_grant = 1'b1; tick(); sched_grant = 1'b0; crc_delim = 1'b0;

    // R9 disable during commitment
    cfg_en = 1'b0;
    tick(); tick();
    check("R9 no abort count", 32'(msg_count), 2);
    finish_tx();
    check("R9 frame completed", 32'(msg_count), 1);
    tick();
    check("R11 flush after commit ends", 32'(msg_count), 0);
    cfg_en = 1'b1;

    // R7 per-message interrupt
    cfg_irq_each = 1'b1;
    push_one(); commit(); finish_tx();
    check("R7 irq set", 32'(tx_irq), 1);
    check("R8 empty after last frame", 32'(empty), 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R7 irq cleared", 32'(tx_irq), 0);
    push_one(); commit();
    tx_done = 1'b1; irq_clr = 1'b1; tick(); tx_done = 1'b0; irq_clr = 1'b0;
    check("R7 set beats clear", 32'(tx_irq), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule